// File: doc/BRIEF.md
# Logical Bitmask Immediate Expander

This block turns a compact three-field immediate code into the full-width bitmask constant it stands for. The code consists of a width-select bit, a rotate amount and a size/run field. Together they describe a contiguous run of ones inside an element whose size is a power of two. The element is repeated across the datapath width and then rotated right. The block is combinational at its core, with a generate-selected output register, and fits in the operand path of an execution unit that must materialise such constants.

The element size comes from the highest set bit of a pattern word made of the width-select bit followed by the inverted size/run field. The low bits of the size/run field give the run length. A per-size alternating-block constant is XORed with a copy of itself shifted by the run length, which places the run in every element in one step. A half-width mode serves narrow operations. In that mode a set width-select bit is rejected and only the lower half of the result is returned.

Top module: `lmi_decode`

## Requirements
- R1: While `rst_n` is low, `mask_o` is zero and `valid_o` is 0.
- R2: With pattern P = {`n_i`, ~`imms_i`} (7 bits), the code is rejected when P has zero or one set bits. A rejected code drives `valid_o` to 0 and `mask_o` to all zeros.
- R3: If h is the index of the highest set bit of P, the element size is 2^h. The run length is (`imms_i` mod 2^h) + 1. With `n_i`=1 in full-width mode, `mask_o` holds exactly `imms_i`+1 ones.
- R4: The element is repeated across all 64 bits. Before rotation, bits 0..run-1 of each element are one and the others are zero, so a valid result is neither all zeros nor all ones.
- R5: The repeated value is rotated right by `immr_i`: result bit i equals unrotated bit (i + `immr_i`) mod 64.
- R6: In half-width mode (`half_i`=1), a code with `n_i`=1 is rejected as in R2.
- R7: In half-width mode, `mask_o[63:32]` is zero and `mask_o[31:0]` equals the low 32 bits of the full-width result for the same fields.
- R8: With the default `OUT_REG`=1, `mask_o` and `valid_o` reflect the fields sampled at the previous rising edge of `clk`. An input change shows no effect before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_i | input | 1 | Half-width mode select |
| n_i | input | 1 | Width-select bit of the code |
| immr_i | input | 6 | Right-rotate amount |
| imms_i | input | 6 | Size and run-length field |
| mask_o | output | 64 | Expanded bitmask constant |
| valid_o | output | 1 | High when the code is accepted |

## Verification
The hardest cases to reach are the rejection boundaries. A run field that fills its whole element leaves a pattern word with a single set bit. The size-64 element sits at the far edge of the shift that builds the run, where the shifted copy falls off the word entirely. A targeted test would miss some of these, so the stimulus sweeps every combination of mode, width-select bit, rotate amount and size field, 16384 codes in all. Each code is compared with a bit-by-bit model that builds the run, repeats it and rotates it. A separate step checks that an input change does not reach the outputs before the clock edge.

// File: rtl/lmi_pkg.sv
package lmi_pkg;
   // Largest supported log2 of the datapath width
   localparam int unsigned LMI_MAX_LOG = 8;
   typedef enum logic {LMI_FULL = 1'b0, LMI_HALF = 1'b1} lmi_mode_e;
endpackage

// File: rtl/lmi_size_detect.sv
module lmi_size_detect #(
   parameter int unsigned PW  = 7,
   parameter int unsigned HBW = $clog2(PW)
) (
   input  logic [PW-1:0]  pat_i,
   output logic [HBW-1:0] top_o,
   output logic           sparse_o
);
   // Highest set bit of the pattern word, scanned from the bottom up
   always_comb begin
      top_o = '0;
      for (int b = 0; b < int'(PW); b++) begin
         if (pat_i[b]) top_o = HBW'(b);
      end
   end

   // One power-of-two test covers both zero and single-bit patterns
   assign sparse_o = ((pat_i & (pat_i - PW'(1))) == '0);
endmodule

// File: rtl/lmi_pattern_gen.sv
module lmi_pattern_gen #(
   parameter int unsigned XLEN_LOG = 6,
   parameter int unsigned HBW      = 3,
   localparam int unsigned XLEN    = 1 << XLEN_LOG,
   localparam int unsigned CW      = XLEN_LOG + 1
) (
   input  logic [HBW-1:0]      top_i,
   input  logic [XLEN_LOG-1:0] imms_i,
   output logic [XLEN-1:0]     elem_o
);
   logic [CW-1:0]   run_full;
   logic [CW-1:0]   run_lim;
   logic [CW-1:0]   run_len;
   logic [XLEN-1:0] base;

   assign run_full = {1'b0, imms_i} + CW'(1);
   assign run_lim  = CW'((CW'(1) << top_i) - CW'(1));
   assign run_len  = run_full & run_lim;

   // Alternating blocks of 2^top ones and zeros (all ones at full size)
   always_comb begin
      for (int i = 0; i < int'(XLEN); i++) begin
         base[i] = ~((i >> top_i) & 1);
      end
   end

   assign elem_o = base ^ (base << run_len);
endmodule

// File: rtl/lmi_rotator.sv
module lmi_rotator #(
   parameter int unsigned XLEN_LOG = 6,
   localparam int unsigned XLEN    = 1 << XLEN_LOG
) (
   input  logic [XLEN-1:0]     data_i,
   input  logic [XLEN_LOG-1:0] amt_i,
   output logic [XLEN-1:0]     data_o
);
   logic [XLEN-1:0] stage [XLEN_LOG+1];

   assign stage[0] = data_i;

   for (genvar s = 0; s < int'(XLEN_LOG); s++) begin : g_stage
      localparam int unsigned K = 1 << s;
      logic [XLEN-1:0] rot;
      assign rot          = {stage[s][K-1:0], stage[s][XLEN-1:K]};
      assign stage[s + 1] = amt_i[s] ? rot : stage[s];
   end

   assign data_o = stage[XLEN_LOG];
endmodule

// File: rtl/lmi_decode.sv
module lmi_decode #(
   parameter int unsigned XLEN_LOG = 6,
   parameter bit          OUT_REG  = 1'b1,
   localparam int unsigned XLEN    = 1 << XLEN_LOG,
   localparam int unsigned HALF    = XLEN / 2,
   localparam int unsigned PW      = XLEN_LOG + 1,
   localparam int unsigned HBW     = $clog2(PW)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                half_i,
   input  logic                n_i,
   input  logic [XLEN_LOG-1:0] immr_i,
   input  logic [XLEN_LOG-1:0] imms_i,
   output logic [XLEN-1:0]     mask_o,
   output logic                valid_o
);
   import lmi_pkg::*;

   if (XLEN_LOG < 2 || XLEN_LOG > LMI_MAX_LOG) begin : g_bad_width
      $error("lmi_decode: XLEN_LOG out of range");
   end

   logic [PW-1:0]   pat;
   logic [HBW-1:0]  top;
   logic            sparse;
   logic [XLEN-1:0] elem;
   logic [XLEN-1:0] rotd;
   logic            ok;
   logic [XLEN-1:0] res;
   lmi_mode_e       mode;

   assign mode = lmi_mode_e'(half_i);
   assign pat  = {n_i, ~imms_i};

   lmi_size_detect #(.PW(PW), .HBW(HBW)) size_i (
      .pat_i    (pat),
      .top_o    (top),
      .sparse_o (sparse)
   );

   lmi_pattern_gen #(.XLEN_LOG(XLEN_LOG), .HBW(HBW)) gen_i (
      .top_i  (top),
      .imms_i (imms_i),
      .elem_o (elem)
   );

   lmi_rotator #(.XLEN_LOG(XLEN_LOG)) rot_i (
      .data_i (elem),
      .amt_i  (immr_i),
      .data_o (rotd)
   );

   always_comb begin
      ok  = ~sparse & ~((mode == LMI_HALF) & n_i);
      res = '0;
      if (ok) begin
         if (mode == LMI_HALF) res = {{HALF{1'b0}}, rotd[HALF-1:0]};
         else                  res = rotd;
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_o  <= '0;
            valid_o <= 1'b0;
         end else begin
            mask_o  <= res;
            valid_o <= ok;
         end
      end
   end else begin : g_comb
      assign mask_o  = res;
      assign valid_o = ok;
   end
endmodule

// File: rtl/lmi_decode_chk.sv
module lmi_decode_chk #(
   parameter int unsigned XLEN_LOG = 6,
   parameter bit          OUT_REG  = 1'b1,
   localparam int unsigned XLEN    = 1 << XLEN_LOG,
   localparam int unsigned HALF    = XLEN / 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                half_i,
   input logic                n_i,
   input logic [XLEN_LOG-1:0] imms_i,
   input logic [XLEN-1:0]     mask_o,
   input logic                valid_o
);
   logic                h_q;
   logic                n_q;
   logic [XLEN_LOG-1:0] s_q;

   // Fields aligned with the outputs they produced
   if (OUT_REG) begin : g_al
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            h_q <= 1'b0;
            n_q <= 1'b0;
            s_q <= '0;
         end else begin
            h_q <= half_i;
            n_q <= n_i;
            s_q <= imms_i;
         end
      end
   end else begin : g_al
      assign h_q = half_i;
      assign n_q = n_i;
      assign s_q = imms_i;
   end

   // R2
   reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> mask_o == '0);

   // R3
   run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && n_q && !h_q) |-> $countones(mask_o) == int'(s_q) + 1);

   // R4
   not_trivial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !h_q) |-> (mask_o != '0 && mask_o != '1));

   // R6
   half_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_q && n_q) |-> !valid_o);

   // R7
   half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      h_q |-> mask_o[XLEN-1:HALF] == '0);
endmodule

bind lmi_decode lmi_decode_chk #(.XLEN_LOG(XLEN_LOG), .OUT_REG(OUT_REG)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .half_i  (half_i),
   .n_i     (n_i),
   .imms_i  (imms_i),
   .mask_o  (mask_o),
   .valid_o (valid_o)
);

// File: tb/lmi_decode_tb_top.sv
module lmi_decode_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        half_i = 1'b0;
   logic        n_i = 1'b0;
   logic [5:0]  immr_i = '0;
   logic [5:0]  imms_i = '0;
   logic [63:0] mask_o;
   logic        valid_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lmi_decode dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .half_i  (half_i),
      .n_i     (n_i),
      .immr_i  (immr_i),
      .imms_i  (imms_i),
      .mask_o  (mask_o),
      .valid_o (valid_o)
   );

   // Bit-by-bit reference: build run, repeat over element, rotate right
   task automatic ref_model(input bit h, input bit n, input int rr, input int ss,
                            output bit v, output logic [63:0] m);
      logic [6:0]  p;
      logic [63:0] e;
      int          top;
      int          sz;
      int          run;
      p   = {n, ~ss[5:0]};
      top = 0;
      for (int b = 6; b >= 0; b--) begin
         if (p[b] && top == 0) top = b;
      end
      v = ($countones(p) >= 2) && !(h && n);
      m = '0;
      if (v) begin
         sz  = 1 << top;
         run = (ss % sz) + 1;
         for (int i = 0; i < 64; i++) e[i] = ((i % sz) < run);
         for (int i = 0; i < 64; i++) m[i] = e[(i + rr) % 64];
         if (h) m[63:32] = '0;
      end
   endtask

   task automatic check(input string tag, input logic [63:0] am, input logic av,
                        input logic [63:0] em, input logic ev);
      checks++;
      if (am !== em || av !== ev) begin
         errors++;
         $display("FAIL %s: got mask=%h valid=%b, expected mask=%h valid=%b",
                  tag, am, av, em, ev);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      bit          ev;
      logic [63:0] em;
      // R1: reset holds outputs low even with a valid code applied
      n_i = 1'b1; imms_i = 6'd3;
      repeat (3) @(negedge clk);
      check("R1", mask_o, valid_o, '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: new inputs must not reach outputs before the next rising edge
      n_i = 1'b0; half_i = 1'b0; immr_i = 6'd1; imms_i = 6'd0;
      #1;
      check("R8", mask_o, valid_o, 64'h0000_0000_0000_000F, 1'b1);
      @(negedge clk);
      check("R8", mask_o, valid_o, 64'h8000_0000_8000_0000, 1'b1);
      // Full sweep of mode, width bit, rotate and size fields
      for (int h = 0; h < 2; h++) begin
         for (int n = 0; n < 2; n++) begin
            for (int rr = 0; rr < 64; rr++) begin
               for (int ss = 0; ss < 64; ss++) begin
                  half_i = h[0]; n_i = n[0]; immr_i = rr[5:0]; imms_i = ss[5:0];
                  @(negedge clk);
                  ref_model(h[0], n[0], rr, ss, ev, em);
                  if (h == 1 && n == 1)  check("R6", mask_o, valid_o, em, ev);
                  else if (!ev)          check("R2", mask_o, valid_o, em, ev);
                  else if (h == 1)       check("R7", mask_o, valid_o, em, ev);
                  else if (rr == 0)      check("R3/R4", mask_o, valid_o, em, ev);
                  else                   check("R5", mask_o, valid_o, em, ev);
               end
            end
         end
      end
      finish_run();
   end
endmodule